// File: doc/BRIEF.md
# Subaddressed I2C Memory Window

This block is the byte-level protocol layer of an I2C slave that gives an external host a window into a processor's byte-wide local memory. An existing bit engine detects START, STOP and repeated START, shifts bytes in and out, and hands this block one event per received byte. The block then decides whether to acknowledge each byte, latches a 16-bit memory address, and drives single-cycle write and read strobes on the memory port. The memory answers a read one cycle after the strobe.

A host opens the window with write device address 0x22 followed by a window subaddress. It then sends two address bytes, high byte first, and any number of data bytes. Each data byte is written to memory as soon as it arrives, and the pointer moves up by one after every byte. The latched address outlives the telegram. A later telegram that targets the data subaddress writes from that address again. A repeated START with read device address 0x23 returns bytes from that address. Any advance made inside an earlier telegram is discarded whenever a new telegram addresses the device.

Top module: `i2cwin_top`

## Requirements
- R1: While reset is applied, and in the first cycles after it, `ack_valid`, `mem_we`, `mem_re` and `tx_valid` are all low.
- R2: The first byte after a START or repeated START is the device address. 0x22 (write) and 0x23 (read) are acknowledged (`ack_ok`=1). Any other value is refused (`ack_ok`=0), and every later byte of that telegram is refused and causes no memory strobe.
- R3: After 0x22, subaddresses 0x78 and 0x79 are acknowledged and open an address phase, and 0x7C (data subaddress) is acknowledged and opens a data phase. Any other subaddress is refused, and the rest of the telegram is ignored as in R2.
- R4: In the address phase, the two following bytes are acknowledged and form the latched address {high, low}. Each data byte after that is acknowledged and produces one `mem_we` pulse in the next cycle, with `mem_wdata` equal to the byte and `mem_addr` equal to the latched address plus the number of earlier data bytes in the same telegram.
- R5: The latched address is kept across telegrams. A write telegram using subaddress 0x7C starts writing at the latched address, not at the address reached by the previous telegram.
- R6: After device address 0x23, each `rd_req` pulse produces one `mem_re` pulse in the next cycle. Its `mem_addr` starts at the latched address and increases by one per request. Two cycles after `mem_re`, `tx_valid` pulses with `tx_data` equal to the byte the memory returned.
- R7: The memory pointer wraps from 0xFFFF to 0x0000 for both writes and reads.
- R8: A `byte_valid` or `rd_req` that falls in the same cycle as `evt_start` or `evt_stop` is dropped: no `ack_valid`, no `mem_we` and no `mem_re` follow it.
- R9: `rd_req` outside the read phase causes no `mem_re` and no `tx_valid`. A byte received during the read phase is refused and causes no write.
- R10: Every `byte_valid` not dropped under R8 produces exactly one `ack_valid` pulse in the next cycle. No `ack_valid` appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_start | input | 1 | One-cycle pulse for START or repeated START from the bit engine |
| evt_stop | input | 1 | One-cycle pulse for STOP from the bit engine |
| byte_valid | input | 1 | One-cycle pulse: a received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| rd_req | input | 1 | One-cycle pulse: the bit engine needs the next byte to send |
| ack_valid | output | 1 | Acknowledge decision for the last byte is valid |
| ack_ok | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_valid | output | 1 | One-cycle pulse: `tx_data` holds the next byte to send |
| tx_data | output | 8 | Byte to send to the host |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Single-cycle memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |

## Verification
A bus event and a byte or read request from the bit engine can land in the same clock cycle. The case to guard against is a STOP or repeated START that coincides with the last data byte or the last read request. The bench drives `byte_valid` together with `evt_stop`, and separately `rd_req` together with `evt_stop` while the read phase is open. It then expects no acknowledge and no memory strobe in the following cycle. After that it sends a fresh telegram to confirm that the latched address was left intact.

// File: rtl/i2cwin_pkg.sv
package i2cwin_pkg;

  // Position of the current byte within a telegram
  typedef enum logic [2:0] {
    PH_IDLE,   // no telegram open
    PH_DEV,    // expecting device address
    PH_SUB,    // expecting subaddress
    PH_AHI,    // expecting address high byte
    PH_ALO,    // expecting address low byte
    PH_WR,     // data bytes go to memory
    PH_RD,     // host reads from memory
    PH_SKIP    // telegram refused, ignore until next event
  } phase_t;

endpackage

// File: rtl/i2cwin_ctrl.sv
module i2cwin_ctrl
  import i2cwin_pkg::*;
#(
  parameter logic [7:0] DEV_WR  = 8'h22,
  parameter logic [7:0] SUB_WA  = 8'h78,
  parameter logic [7:0] SUB_WB  = 8'h79,
  parameter logic [7:0] SUB_DAT = 8'h7C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_start,
  input  logic       evt_stop,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       rd_req,
  output logic       ack_valid,
  output logic       ack_ok,
  output logic       ld_hi,
  output logic       ld_lo,
  output logic       reload,
  output logic       wr_go,
  output logic       rd_go
);

  localparam logic [7:0] DEV_RD = DEV_WR | 8'h01;

  phase_t phase_q, phase_d;
  logic   ack_ok_d;
  logic   bus_evt, byte_go, req_go;

  assign bus_evt = evt_start | evt_stop;
  assign byte_go = byte_valid & ~bus_evt;
  assign req_go  = rd_req & ~bus_evt;

  // Next-state and control decode
  always_comb begin
    phase_d  = phase_q;
    ack_ok_d = 1'b0;
    ld_hi    = 1'b0;
    ld_lo    = 1'b0;
    reload   = 1'b0;
    wr_go    = 1'b0;
    rd_go    = 1'b0;
    if (evt_start) begin
      phase_d = PH_DEV;
    end else if (evt_stop) begin
      phase_d = PH_IDLE;
    end else if (byte_go) begin
      unique case (phase_q)
        PH_DEV: begin
          if (byte_data == DEV_WR) begin
            ack_ok_d = 1'b1;
            reload   = 1'b1;
            phase_d  = PH_SUB;
          end else if (byte_data == DEV_RD) begin
            ack_ok_d = 1'b1;
            reload   = 1'b1;
            phase_d  = PH_RD;
          end else begin
            phase_d  = PH_SKIP;
          end
        end
        PH_SUB: begin
          if (byte_data == SUB_WA || byte_data == SUB_WB) begin
            ack_ok_d = 1'b1;
            phase_d  = PH_AHI;
          end else if (byte_data == SUB_DAT) begin
            ack_ok_d = 1'b1;
            phase_d  = PH_WR;
          end else begin
            phase_d  = PH_SKIP;
          end
        end
        PH_AHI: begin
          ack_ok_d = 1'b1;
          ld_hi    = 1'b1;
          phase_d  = PH_ALO;
        end
        PH_ALO: begin
          ack_ok_d = 1'b1;
          ld_lo    = 1'b1;
          phase_d  = PH_WR;
        end
        PH_WR: begin
          ack_ok_d = 1'b1;
          wr_go    = 1'b1;
        end
        default: ack_ok_d = 1'b0;
      endcase
    end else if (req_go && phase_q == PH_RD) begin
      rd_go = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      ack_valid <= byte_go;
      ack_ok    <= ack_ok_d;
    end
  end

  // R8: a bus event cancels any byte or request in the same cycle
  assert_event_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |-> !wr_go && !rd_go && !ld_hi && !ld_lo);

  // R9: memory reads are only started in the read phase
  assert_read_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> phase_q == PH_RD);

endmodule

// File: rtl/i2cwin_ptr.sv
module i2cwin_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        byte_data,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              reload,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] latch_q, latch_d, cur_d;
  logic              latch_en, cur_en;

  always_comb begin
    latch_d  = {hi_q, byte_data};
    latch_en = ld_lo;
    cur_en   = ld_lo | reload | step;
    if (ld_lo)       cur_d = latch_d;
    else if (reload) cur_d = latch_q;
    else             cur_d = cur_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      latch_q  <= '0;
      cur_addr <= '0;
    end else begin
      if (ld_hi)    hi_q     <= byte_data[HI_W-1:0];
      if (latch_en) latch_q  <= latch_d;
      if (cur_en)   cur_addr <= cur_d;
    end
  end

  // R5: a new telegram resumes from the latched address
  assert_reload_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload && !ld_lo |=> cur_addr == $past(latch_q));

endmodule

// File: rtl/i2cwin_port.sv
module i2cwin_port #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [7:0]        byte_data,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);

  logic re_q;
  logic addr_en;

  assign addr_en = wr_go | rd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      re_q      <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      mem_we   <= wr_go;
      mem_re   <= rd_go;
      re_q     <= mem_re;
      tx_valid <= re_q;
      if (addr_en) mem_addr  <= cur_addr;
      if (wr_go)   mem_wdata <= byte_data;
      if (re_q)    tx_data   <= mem_rdata;
    end
  end

  // R6: each read strobe yields one transmit byte two cycles later
  assert_tx_after_re_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ##1 tx_valid);

  // R4: the port never writes and reads in the same cycle
  assert_we_re_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

// File: rtl/i2cwin_top.sv
module i2cwin_top #(
  parameter int         ADDR_W  = 16,
  parameter logic [7:0] DEV_WR  = 8'h22,
  parameter logic [7:0] SUB_WA  = 8'h78,
  parameter logic [7:0] SUB_WB  = 8'h79,
  parameter logic [7:0] SUB_DAT = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start,
  input  logic              evt_stop,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              rd_req,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);

  // Reset asserts asynchronously and releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic ld_hi, ld_lo, reload, wr_go, rd_go, step;
  logic [ADDR_W-1:0] cur_addr;

  assign step = wr_go | rd_go;

  i2cwin_ctrl #(
    .DEV_WR (DEV_WR),
    .SUB_WA (SUB_WA),
    .SUB_WB (SUB_WB),
    .SUB_DAT(SUB_DAT)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .rd_req    (rd_req),
    .ack_valid (ack_valid),
    .ack_ok    (ack_ok),
    .ld_hi     (ld_hi),
    .ld_lo     (ld_lo),
    .reload    (reload),
    .wr_go     (wr_go),
    .rd_go     (rd_go)
  );

  i2cwin_ptr #(.ADDR_W(ADDR_W)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .byte_data(byte_data),
    .ld_hi    (ld_hi),
    .ld_lo    (ld_lo),
    .reload   (reload),
    .step     (step),
    .cur_addr (cur_addr)
  );

  i2cwin_port #(.ADDR_W(ADDR_W)) i_port (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_go    (wr_go),
    .rd_go    (rd_go),
    .cur_addr (cur_addr),
    .byte_data(byte_data),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .mem_re   (mem_re),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  // R10: one acknowledge decision per accepted byte, in the next cycle
  assert_ack_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    byte_valid && !evt_start && !evt_stop |=> ack_valid);

  assert_no_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(byte_valid && !evt_start && !evt_stop) |=> !ack_valid);

  // R4: every memory write belongs to an acknowledged byte
  assert_we_acked_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_we |-> ack_valid && ack_ok);

  // R8: a bus event leaves no strobe behind
  assert_evt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    evt_start || evt_stop |=> !mem_we && !mem_re && !ack_valid);

endmodule

// File: tb/test_i2cwin_top.sv
`timescale 1ns/1ps
module test_i2cwin_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_start, evt_stop, byte_valid, rd_req;
  logic [7:0]  byte_data;
  logic        ack_valid, ack_ok, tx_valid, mem_we, mem_re;
  logic [7:0]  tx_data, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2cwin_top i_i2cwin_top (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_data(tx_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  // Memory model contents are a function of the address
  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= mem_val(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_ev();
    evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
  endtask

  task automatic stop_ev();
    evt_stop = 1'b1;
    @(negedge clk); evt_stop = 1'b0;
  endtask

  // Send one byte and check acknowledge and the write strobe
  task automatic send(input logic [7:0] b, input bit exp_ack, input bit exp_we,
                      input logic [15:0] exp_a, input string req);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
    chk({req, " ack_valid R10"}, ack_valid, 1);
    chk({req, " ack_ok"}, ack_ok, exp_ack);
    chk({req, " mem_we"}, mem_we, exp_we);
    if (exp_we) begin
      chk({req, " mem_addr"}, mem_addr, exp_a);
      chk({req, " mem_wdata"}, mem_wdata, b);
    end
  endtask

  task automatic read(input logic [15:0] exp_a, input string req);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk({req, " mem_re"}, mem_re, 1);
    chk({req, " mem_addr"}, mem_addr, exp_a);
    @(negedge clk);
    @(negedge clk);
    chk({req, " tx_valid"}, tx_valid, 1);
    chk({req, " tx_data"}, tx_data, mem_val(exp_a));
  endtask

  task automatic open_win(input logic [7:0] sub, input logic [15:0] a);
    start_ev();
    send(8'h22, 1, 0, 0, "R2 dev");
    send(sub, 1, 0, 0, "R3 sub");
    send(a[15:8], 1, 0, 0, "R4 ahi");
    send(a[7:0], 1, 0, 0, "R4 alo");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    int len;
    void'($urandom(32'd4242));
    rst_n = 1'b0; evt_start = 0; evt_stop = 0; byte_valid = 0; rd_req = 0;
    byte_data = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
    chk("R1 tx_valid", tx_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mem_we after", mem_we, 0);

    // R2 unknown device address refused, rest ignored
    start_ev();
    send(8'h44, 0, 0, 0, "R2 bad dev");
    send(8'h78, 0, 0, 0, "R2 skip");
    send(8'h11, 0, 0, 0, "R2 skip");
    stop_ev();

    // R3 unknown subaddress refused
    start_ev();
    send(8'h22, 1, 0, 0, "R3 dev");
    send(8'h55, 0, 0, 0, "R3 bad sub");
    send(8'h10, 0, 0, 0, "R3 skip");
    stop_ev();

    // R7 wrap on write and read
    open_win(8'h78, 16'hFFFF);
    send(8'hA1, 1, 1, 16'hFFFF, "R7 wr");
    send(8'hA2, 1, 1, 16'h0000, "R7 wr wrap");
    start_ev();
    send(8'h23, 1, 0, 0, "R6 rd dev");
    read(16'hFFFF, "R7 rd");
    read(16'h0000, "R7 rd wrap");
    stop_ev();

    // R8 byte coinciding with stop is dropped
    open_win(8'h79, 16'h1234);
    send(8'h01, 1, 1, 16'h1234, "R4 wr");
    byte_valid = 1; byte_data = 8'h02; evt_stop = 1;
    @(negedge clk); byte_valid = 0; evt_stop = 0;
    chk("R8 ack_valid", ack_valid, 0);
    chk("R8 mem_we", mem_we, 0);
    // R9 read request outside read phase
    rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk("R9 mem_re", mem_re, 0);
    @(negedge clk); @(negedge clk);
    chk("R9 tx_valid", tx_valid, 0);
    // R8 read request coinciding with stop
    start_ev();
    send(8'h23, 1, 0, 0, "R6 rd dev");
    read(16'h1234, "R5 rd resume");
    send(8'h77, 0, 0, 0, "R9 byte in read");
    rd_req = 1; evt_stop = 1;
    @(negedge clk); rd_req = 0; evt_stop = 0;
    chk("R8 mem_re", mem_re, 0);

    // Random telegrams: write, resume write via data subaddress, read
    for (int it = 0; it < 20; it++) begin
      base = 16'($urandom);
      len = 1 + int'($urandom % 5);
      open_win((it % 2) ? 8'h79 : 8'h78, base);
      for (int k = 0; k < len; k++)
        send(8'($urandom), 1, 1, base + 16'(k), "R4 rnd wr");
      stop_ev();
      start_ev();
      send(8'h22, 1, 0, 0, "R2 dev");
      send(8'h7C, 1, 0, 0, "R3 data sub");
      for (int k = 0; k < len; k++)
        send(8'($urandom), 1, 1, base + 16'(k), "R5 resume wr");
      start_ev();
      send(8'h23, 1, 0, 0, "R2 rd dev");
      for (int k = 0; k < len; k++)
        read(base + 16'(k), "R6 rnd rd");
      stop_ev();
      @(negedge clk);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule